// File: doc/BRIEF.md
# Raster Timing Generator

This block produces the horizontal and vertical timing for a display pipeline whose pixel rate is a fraction of the system clock. A pixel-enable strobe marks each pixel period. On each strobe a horizontal position counter advances, and a vertical line counter follows it. Every timing position is held in a writable field, and reset loads a 640x480 frame. The active pixels and lines come first in each count, with the porches and sync pulses after them. Because of this layout the two counters can be used directly as pixel coordinates.

Sync and display-enable are flags held in flip-flops. Each flag is set when its counter equals a programmed "on" position and cleared when the counter equals a programmed "off" position. No magnitude comparison is used, so the logic per field stays a single equality comparator even though the fields are writable. A second flop stage sits between the flags and the output pins, so every pin is driven straight from a flop. Downstream logic must force the colour data to black whenever `disp_en` is low.

Top module: `raster_timing_gen`

## Requirements
- R1: Synchronous reset, even with `pena` low, clears both counters to 0 and sets `hsync_n`=1, `vsync_n`=1 and `disp_en`=0. It also loads the timing fields. Horizontal: active on 0, active off 640, sync on 656, sync off 752, last position 799. Vertical: active on 0, active off 480, sync on 490, sync off 492, last line 524.
- R2: While `pena` is low, the counters and all three outputs hold their values.
- R3: Each enable advances `h_pos` by one, and `h_pos` wraps to 0 on the enable after it equals the horizontal last value. `v_pos` advances only on that wrapping enable, and it wraps to 0 after the vertical last value.
- R4: The horizontal sync flag is set on an enable where `h_pos` equals sync-on. It is cleared on an enable where `h_pos` equals sync-off, and set wins if both match. After the k-th enable since reset, `hsync_n` is low exactly when the horizontal position at enable k-2 lies in [sync-on, sync-off).
- R5: The vertical flags are updated only on a wrapping enable, against the line being entered. After enable k, `vsync_n` is low exactly when the line at enable k-1 lies in [sync-on, sync-off).
- R6: The three pins are registers loaded only on an enable, from the flag state before that enable.
- R7: `disp_en` is the AND of a horizontal active flag and a vertical active flag. After enable k it is high exactly when, at enable k-2, the position lies in the horizontal active window and the line lies in the vertical one. The vertical active flag comes out of reset set, so a vertical active-on value of 0 covers line 0.
- R8: A write (`wr_en`=1) selects the axis with `wr_addr[3]` (0 horizontal, 1 vertical) and the field with `wr_addr[2:0]`: 0 active-on, 1 active-off, 2 sync-on, 3 sync-off, 4 last. It loads `wr_data` at the next clock, whatever `pena` is. Field codes 5 to 7 change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| pena | input | 1 | Pixel enable strobe, one clock per pixel |
| wr_en | input | 1 | Timing field write strobe |
| wr_addr | input | 4 | Axis select (bit 3) and field code (bits 2:0) |
| wr_data | input | 10 | Value for the selected field |
| h_pos | output | 10 | Horizontal position counter |
| v_pos | output | 10 | Vertical line counter |
| hsync_n | output | 1 | Horizontal sync, active low, registered |
| vsync_n | output | 1 | Vertical sync, active low, registered |
| disp_en | output | 1 | Active-video flag, registered |

## Verification
On every cycle the assertions check the following: nothing moves without an enable, each counter wraps at its programmed last value, and the line counter moves only on a horizontal wrap. They also check that a flag is set or cleared on the enable after its equality match, and that ignored field codes leave the timing fields untouched. Only the bench scenarios show the end-to-end pin timing: the two-enable lag of horizontal sync and display-enable, the one-enable lag of vertical sync, and the default 640x480 positions after reset. The scenarios also cover reprogrammed compact frames with a non-zero active start, sparse enables, and a reset taken with the enable held low.

// File: rtl/raster_pkg.sv
package raster_pkg;

    localparam int CW       = 10;
    localparam int FIELD_W  = 3;
    localparam int ADDR_W   = FIELD_W + 1;
    localparam int NUM_AXES = 2;
    localparam int AX_H     = 0;
    localparam int AX_V     = 1;

    typedef logic [CW-1:0] pos_t;

    // One axis worth of programmable positions
    typedef struct packed {
        pos_t act_on;
        pos_t act_off;
        pos_t sync_on;
        pos_t sync_off;
        pos_t last;
    } axis_cfg_t;

    typedef struct packed {
        logic act;
        logic sync;
    } axis_flags_t;

    typedef enum logic [FIELD_W-1:0] {
        FLD_ACT_ON   = 3'd0,
        FLD_ACT_OFF  = 3'd1,
        FLD_SYNC_ON  = 3'd2,
        FLD_SYNC_OFF = 3'd3,
        FLD_LAST     = 3'd4
    } field_e;

    // Reset timing: 640x480 frame, active region first
    function automatic axis_cfg_t axis_default(int axis);
        axis_cfg_t c;
        if (axis == AX_H) begin
            c.act_on   = pos_t'(0);
            c.act_off  = pos_t'(640);
            c.sync_on  = pos_t'(656);
            c.sync_off = pos_t'(752);
            c.last     = pos_t'(799);
        end else begin
            c.act_on   = pos_t'(0);
            c.act_off  = pos_t'(480);
            c.sync_on  = pos_t'(490);
            c.sync_off = pos_t'(492);
            c.last     = pos_t'(524);
        end
        return c;
    endfunction

    // Equality-only set/clear; set has priority
    function automatic logic edge_flag(logic cur, pos_t pos, pos_t on_at, pos_t off_at);
        if (pos == on_at)  return 1'b1;
        if (pos == off_at) return 1'b0;
        return cur;
    endfunction

endpackage

// File: rtl/raster_field_regs.sv
module raster_field_regs
    import raster_pkg::*;
#(
    parameter int AXIS_ID = 0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [CW-1:0]     wr_data,
    output axis_cfg_t         cfg
);

    localparam logic AXIS_BIT = 1'(AXIS_ID);

    logic   hit;
    field_e fld;

    assign hit = wr_en && (wr_addr[ADDR_W-1] == AXIS_BIT);
    assign fld = field_e'(wr_addr[FIELD_W-1:0]);

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg <= axis_default(AXIS_ID);
        end else if (hit) begin
            case (fld)
                FLD_ACT_ON:   cfg.act_on   <= wr_data;
                FLD_ACT_OFF:  cfg.act_off  <= wr_data;
                FLD_SYNC_ON:  cfg.sync_on  <= wr_data;
                FLD_SYNC_OFF: cfg.sync_off <= wr_data;
                FLD_LAST:     cfg.last     <= wr_data;
                default: ;
            endcase
        end
    end

    // R8: unused field codes leave every field alone
    p_ignore_r8: assert property (@(posedge clk) disable iff (rst)
        (wr_en && (wr_addr[FIELD_W-1:0] > 3'd4)) |=> $stable(cfg));

    // R8: a write to the last-position field lands on the next clock
    p_write_last_r8: assert property (@(posedge clk) disable iff (rst)
        (hit && (wr_addr[FIELD_W-1:0] == 3'd4)) |=> (cfg.last == $past(wr_data)));

endmodule

// File: rtl/raster_axis.sv
module raster_axis
    import raster_pkg::*;
#(
    parameter bit NEXT_CMP = 1'b0,
    parameter bit RST_ACT  = 1'b0
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        step,
    input  axis_cfg_t   cfg,
    output pos_t        cnt,
    output logic        wrap,
    output axis_flags_t flags
);

    pos_t cnt_nxt;
    pos_t cmp;

    assign wrap    = (cnt == cfg.last);
    assign cnt_nxt = wrap ? '0 : cnt + 1'b1;

    // Variant: compare the current count, or the count being entered
    generate
        if (NEXT_CMP) begin : g_next
            assign cmp = cnt_nxt;
        end else begin : g_cur
            assign cmp = cnt;
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt        <= '0;
            flags.act  <= RST_ACT;
            flags.sync <= 1'b0;
        end else if (step) begin
            cnt        <= cnt_nxt;
            flags.act  <= edge_flag(flags.act,  cmp, cfg.act_on,  cfg.act_off);
            flags.sync <= edge_flag(flags.sync, cmp, cfg.sync_on, cfg.sync_off);
        end
    end

    p_hold_r2: assert property (@(posedge clk) disable iff (rst)
        !step |=> ($stable(cnt) && $stable(flags)));

    p_wrap_r3: assert property (@(posedge clk) disable iff (rst)
        (step && wrap) |=> (cnt == '0));

    p_sync_set_r4: assert property (@(posedge clk) disable iff (rst)
        (step && (cmp == cfg.sync_on)) |=> flags.sync);

    p_sync_clr_r4: assert property (@(posedge clk) disable iff (rst)
        (step && (cmp == cfg.sync_off) && (cmp != cfg.sync_on)) |=> !flags.sync);

    p_act_set_r7: assert property (@(posedge clk) disable iff (rst)
        (step && (cmp == cfg.act_on)) |=> flags.act);

    p_act_clr_r7: assert property (@(posedge clk) disable iff (rst)
        (step && (cmp == cfg.act_off) && (cmp != cfg.act_on)) |=> !flags.act);

endmodule

// File: rtl/raster_pin_stage.sv
module raster_pin_stage
    import raster_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        pena,
    input  axis_flags_t h_flags,
    input  axis_flags_t v_flags,
    output logic        hsync_n,
    output logic        vsync_n,
    output logic        disp_en
);

    always_ff @(posedge clk) begin
        if (rst) begin
            hsync_n <= 1'b1;
            vsync_n <= 1'b1;
            disp_en <= 1'b0;
        end else if (pena) begin
            hsync_n <= ~h_flags.sync;
            vsync_n <= ~v_flags.sync;
            disp_en <= h_flags.act & v_flags.act;
        end
    end

    p_pins_hold_r6: assert property (@(posedge clk) disable iff (rst)
        !pena |=> $stable({hsync_n, vsync_n, disp_en}));

    // R7: the pin can only rise if the horizontal flag was already up
    p_de_needs_h_r7: assert property (@(posedge clk) disable iff (rst)
        $rose(disp_en) |-> $past(h_flags.act));

endmodule

// File: rtl/raster_timing_gen.sv
module raster_timing_gen
    import raster_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              pena,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [CW-1:0]     wr_data,
    output logic [CW-1:0]     h_pos,
    output logic [CW-1:0]     v_pos,
    output logic              hsync_n,
    output logic              vsync_n,
    output logic              disp_en
);

    axis_cfg_t               cfg   [NUM_AXES];
    pos_t                    cnt   [NUM_AXES];
    axis_flags_t             flags [NUM_AXES];
    logic [NUM_AXES-1:0]     wrap;
    logic [NUM_AXES-1:0]     step;

    assign step[AX_H] = pena;
    assign step[AX_V] = pena & wrap[AX_H];

    generate
        for (genvar a = 0; a < NUM_AXES; a++) begin : g_axis
            raster_field_regs #(.AXIS_ID(a)) u_regs (
                .clk     (clk),
                .rst     (rst),
                .wr_en   (wr_en),
                .wr_addr (wr_addr),
                .wr_data (wr_data),
                .cfg     (cfg[a])
            );

            raster_axis #(
                .NEXT_CMP (a == AX_V),
                .RST_ACT  (a == AX_V)
            ) u_axis (
                .clk   (clk),
                .rst   (rst),
                .step  (step[a]),
                .cfg   (cfg[a]),
                .cnt   (cnt[a]),
                .wrap  (wrap[a]),
                .flags (flags[a])
            );
        end
    endgenerate

    raster_pin_stage u_pins (
        .clk     (clk),
        .rst     (rst),
        .pena    (pena),
        .h_flags (flags[AX_H]),
        .v_flags (flags[AX_V]),
        .hsync_n (hsync_n),
        .vsync_n (vsync_n),
        .disp_en (disp_en)
    );

    assign h_pos = cnt[AX_H];
    assign v_pos = cnt[AX_V];

    p_vstep_r3: assert property (@(posedge clk) disable iff (rst)
        (pena && !wrap[AX_H]) |=> $stable(v_pos));

    p_frame_wrap_r3: assert property (@(posedge clk) disable iff (rst)
        (step[AX_V] && wrap[AX_V]) |=> (v_pos == '0));

endmodule

// File: tb/raster_timing_gen_tb.sv
module raster_timing_gen_tb;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 200000;

    typedef struct {
        int hc;
        int vc;
        bit hs_n;
        bit vs_n;
        bit de;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       pena = 1'b0;
    logic       wr_en = 1'b0;
    logic [3:0] wr_addr = '0;
    logic [9:0] wr_data = '0;
    logic [9:0] h_pos, v_pos;
    logic       hsync_n, vsync_n, disp_en;

    int    checks = 0;
    int    failures = 0;
    int    k = 0;
    int    cf [2][5];
    string scen = "start";
    bit    done = 1'b0;
    exp_t  q [$];
    exp_t  last_e;

    always #(CLK_PERIOD/2) clk = ~clk;

    raster_timing_gen u_dut (
        .clk(clk), .rst(rst), .pena(pena),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .h_pos(h_pos), .v_pos(v_pos),
        .hsync_n(hsync_n), .vsync_n(vsync_n), .disp_en(disp_en)
    );

    function automatic exp_t reset_exp();
        exp_t e;
        e.hc = 0; e.vc = 0; e.hs_n = 1'b1; e.vs_n = 1'b1; e.de = 1'b0;
        return e;
    endfunction

    function automatic void load_defaults();
        cf[0] = '{0, 640, 656, 752, 799};
        cf[1] = '{0, 480, 490, 492, 524};
    endfunction

    function automatic bit inwin(int p, int lo, int hi);
        return (p >= lo) && (p < hi);
    endfunction

    // Expected ports after the k-th enable since reset (R3 R4 R5 R7)
    function automatic exp_t predict(int n);
        exp_t e;
        int per   = cf[0][4] + 1;
        int lines = cf[1][4] + 1;
        e.hc   = n % per;
        e.vc   = (n / per) % lines;
        e.hs_n = !((n >= 2) && inwin((n-2) % per, cf[0][2], cf[0][3]));
        e.vs_n = !inwin(((n-1) / per) % lines, cf[1][2], cf[1][3]);
        e.de   = (n >= 2) && inwin((n-2) % per, cf[0][0], cf[0][1])
                          && inwin(((n-2) / per) % lines, cf[1][0], cf[1][1]);
        return e;
    endfunction

    task automatic chk(string req, int act, int expv, string what);
        checks++;
        if (act != expv) begin
            failures++;
            $display("FAIL %s [%s] %s actual=%0d expected=%0d (enable %0d)",
                     req, scen, what, act, expv, k);
        end
    endtask

    task automatic compare(string tag, exp_t e);
        chk({tag, " R3"}, int'(h_pos), e.hc, "h_pos");
        chk({tag, " R3"}, int'(v_pos), e.vc, "v_pos");
        chk({tag, " R4 R6"}, int'(hsync_n), int'(e.hs_n), "hsync_n");
        chk({tag, " R5"}, int'(vsync_n), int'(e.vs_n), "vsync_n");
        chk({tag, " R7"}, int'(disp_en), int'(e.de), "disp_en");
    endtask

    // Monitor: pops one expected item per enable, checks hold otherwise
    initial begin
        bit fire, r;
        last_e = reset_exp();
        forever begin
            @(posedge clk);
            fire = pena;
            r    = rst;
            @(negedge clk);
            if (r) begin
                last_e = reset_exp();
            end else if (fire) begin
                if (q.size() == 0) begin
                    chk("R3", 0, 1, "scoreboard underflow");
                end else begin
                    last_e = q.pop_front();
                    compare("enable", last_e);
                end
            end else begin
                compare("idle R2", last_e);
            end
        end
    end

    // Driver: n enables with gap idle cycles between them
    task automatic run(int n, int gap);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            pena = 1'b1;
            k++;
            q.push_back(predict(k));
            if (gap > 0) begin
                @(negedge clk);
                pena = 1'b0;
                repeat (gap - 1) @(negedge clk);
            end
        end
        @(negedge clk);
        pena = 1'b0;
    endtask

    task automatic wr(int axis, int fld, int val);
        @(negedge clk);
        wr_en   = 1'b1;
        wr_addr = 4'((axis << 3) | fld);
        wr_data = 10'(val);
        @(negedge clk);
        wr_en = 1'b0;
        if (fld < 5) cf[axis][fld] = val;
    endtask

    // Reset taken with pena low; model returns to defaults (R1)
    task automatic do_reset();
        pena = 1'b0;
        repeat (4) @(negedge clk);
        rst = 1'b1;
        k = 0;
        load_defaults();
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1", int'(h_pos), 0, "h_pos after reset");
        chk("R1", int'(v_pos), 0, "v_pos after reset");
        chk("R1", int'(hsync_n), 1, "hsync_n after reset");
        chk("R1", int'(vsync_n), 1, "vsync_n after reset");
        chk("R1", int'(disp_en), 0, "disp_en after reset");
    endtask

    initial begin
        load_defaults();
        do_reset();

        // R1 default horizontal timing, back-to-back then sparse enables
        scen = "R1 default line";
        run(1700, 0);
        run(200, 2);

        // R8 compact frame with non-zero horizontal active start
        scen = "R8 compact frame";
        run(37, 1);
        do_reset();
        wr(0, 0, 2);  wr(0, 1, 9);  wr(0, 2, 9);  wr(0, 3, 11); wr(0, 4, 11);
        wr(1, 0, 0);  wr(1, 1, 4);  wr(1, 2, 5);  wr(1, 3, 6);  wr(1, 4, 6);
        wr(0, 5, 1);  wr(1, 7, 3);  // unused codes, must change nothing
        run(12 * 7 * 3, 3);

        // R1 reset with pena low restores vertical defaults; short lines
        scen = "R1 R5 default vertical";
        run(5, 0);
        do_reset();
        wr(0, 0, 0);  wr(0, 1, 16); wr(0, 2, 17); wr(0, 3, 19); wr(0, 4, 19);
        run(20 * 525 * 2 + 30, 0);

        repeat (4) @(negedge clk);
        chk("R3", q.size(), 0, "scoreboard drained");
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog R3 actual=%0d expected=%0d", WATCHDOG, 0);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule